// File: doc/BRIEF.md
# Reference-Locked Raster Sync Generator

This block produces the horizontal and vertical sync pulses for a video output path. It locks its own pixel and line counters to an incoming timing reference. The reference can come from discrete sync pins: a line sync, a frame sync and a field flag, each with its own polarity. It can also come from timing codes embedded in the pixel stream. Code parsing happens upstream, so in that case the reference arrives here as a one-cycle strobe marking the end of each active line.

After a frame reference, the block waits a programmable number of line references and then a programmable number of pixel clocks before it restarts its raster at pixel 0 of line 0. Both waits may be longer than a line or a frame; they simply carry on across the boundary. Further references that arrive during the wait are dropped.

Once running, the raster wraps at the configured line and frame totals and flips the field flag at every frame wrap. The output line sync sits at the start of each line. The output frame sync covers a window of lines that is programmed separately for each of the two fields. Each output has its own polarity control.

Top module: `vtg_sync_lock`

## Requirements
- R1: With `cfg_embedded`=0 the line reference is the active edge of `hs_in` and the frame reference is the active edge of `vs_in`. The `eav_strobe` input is then ignored. With `cfg_embedded`=1 the pins `hs_in`, `vs_in` and `fid_in` are ignored. Each `eav_strobe` pulse is then a line reference. A strobe is also the frame reference when it is the first strobe after reset or any later strobe that comes a multiple of `line_total` strobes after that first one.
- R2: The input polarity bits `pol_hs_in`, `pol_vs_in` and `pol_fid_in` set which level of `hs_in`, `vs_in` and `fid_in` is active: 1 means high is active and 0 means low is active. A reference is taken on the transition into the active level.
- R3: Take `v_delay`=0 and a frame reference sampled at clock edge k, meaning the input was driven before edge k. The raster then restarts at pixel 0, line 0 on edge k+2+`h_delay`. So `hs_out` first shows its active level in the cycle that follows that edge.
- R4: Take `v_delay`=N>0. The line reference sampled together with the frame reference is not counted. The pixel wait starts on the Nth line reference that follows, and the restart comes 2+`h_delay` edges after the edge that sampled that Nth reference.
- R5: A `h_delay` of `pix_total` or more, and a `v_delay` of `line_total` or more, are honoured exactly and are not clipped.
- R6: Once a frame reference has been accepted, further frame and line references have no effect on the pixel wait. Frame references also leave the line count alone. Until the restart, the restart time therefore depends only on the accepted reference and the line references that the line wait consumes.
- R7: A running raster counts `pix` from 0 to `pix_total`-1 and then moves to the next line. After line `line_total`-1 it returns to line 0 and inverts the field flag.
- R8: `hs_out` is active while the pixel count is below `hs_width`. `pol_hs_out`=1 gives an active-high output and 0 gives an active-low one. Before the first restart after reset, `hs_out` and `vs_out` sit at their inactive levels and `field_out` is 0.
- R9: `vs_out` is active on lines L where start ≤ L < start+width. Field flag 0 uses `vs1_start`/`vs1_width` and field flag 1 uses `vs2_start`/`vs2_width`. `pol_vs_out`=1 gives an active-low output and 0 gives an active-high one.
- R10: On a restart the field flag takes the level of `fid_in` captured at the accepted frame reference: active gives 1 (second field) and inactive gives 0. In embedded mode it takes 0. `field_out` reports the flag.
- R11: When `vs2_start` is all ones and `vs2_width` is 0, `vs_out` never becomes active while the field flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_embedded | input | 1 | 0: discrete sync pins, 1: embedded strobe |
| pol_hs_in | input | 1 | Active level of hs_in (1 = high) |
| pol_vs_in | input | 1 | Active level of vs_in (1 = high) |
| pol_fid_in | input | 1 | Active level of fid_in (1 = high) |
| pol_hs_out | input | 1 | hs_out polarity (1 = active high) |
| pol_vs_out | input | 1 | vs_out polarity (1 = active low) |
| hs_in | input | 1 | Line sync pin |
| vs_in | input | 1 | Frame sync pin |
| fid_in | input | 1 | Field flag pin |
| eav_strobe | input | 1 | One-cycle end-of-active-line strobe |
| h_delay | input | PIX_W | Pixel wait before restart |
| v_delay | input | LINE_W | Line wait before pixel wait |
| pix_total | input | PIX_W | Pixels per line |
| line_total | input | LINE_W | Lines per frame |
| hs_width | input | PIX_W | Output line-sync length in pixels |
| vs1_start | input | LINE_W | First frame-sync line, field flag 0 |
| vs1_width | input | LINE_W | Frame-sync length in lines, field flag 0 |
| vs2_start | input | LINE_W | First frame-sync line, field flag 1 |
| vs2_width | input | LINE_W | Frame-sync length in lines, field flag 1 |
| hs_out | output | 1 | Output line sync |
| vs_out | output | 1 | Output frame sync |
| field_out | output | 1 | Current field flag |

## Verification
The bench builds the block with its default widths, PIX_W=13 and LINE_W=11. That makes the all-ones start line of the progressive setting exactly 2047. The totals are inputs, so the bench programs short lines of 10 to 20 pixels and frames of 2 to 4 lines. With these settings, delays longer than a line or a frame, several line and frame wraps, field flips and the per-field sync windows all fit into a few hundred cycles. Every latency case starts from reset, so the first active `hs_out` cycle can be checked to the exact clock.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        SD_IDLE  = 2'd0,
        SD_LINES = 2'd1,
        SD_PIX   = 2'd2
    } sd_state_t;

endpackage

// File: rtl/vtg_ref_detect.sv
module vtg_ref_detect #(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_embedded,
    input  logic              pol_hs_in,
    input  logic              pol_vs_in,
    input  logic              pol_fid_in,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic              fid_in,
    input  logic              eav_strobe,
    input  logic [LINE_W-1:0] line_total,
    output logic              href,
    output logic              vref,
    output logic              fid_act
);

    typedef struct packed {
        logic              hs_s;
        logic              hs_p;
        logic              vs_s;
        logic              vs_p;
        logic              fid_s;
        logic              eav_s;
        logic [LINE_W-1:0] eline;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    logic hs_norm, vs_norm, fid_norm;
    logic pin_h, pin_v, emb_h, emb_v;
    logic [LINE_W-1:0] eline_last;

    always_comb begin
        // fold polarity so that 1 always means active
        hs_norm    = pol_hs_in  ? hs_in  : ~hs_in;
        vs_norm    = pol_vs_in  ? vs_in  : ~vs_in;
        fid_norm   = pol_fid_in ? fid_in : ~fid_in;
        eline_last = line_total - LINE_W'(1);

        pin_h = rd_q.hs_s & ~rd_q.hs_p;
        pin_v = rd_q.vs_s & ~rd_q.vs_p;
        emb_h = rd_q.eav_s;
        emb_v = rd_q.eav_s & (rd_q.eline == '0);

        rd_d       = rd_q;
        rd_d.hs_s  = hs_norm;
        rd_d.hs_p  = rd_q.hs_s;
        rd_d.vs_s  = vs_norm;
        rd_d.vs_p  = rd_q.vs_s;
        rd_d.fid_s = fid_norm;
        rd_d.eav_s = eav_strobe;
        if (emb_h) begin
            rd_d.eline = (rd_q.eline >= eline_last) ? '0 : rd_q.eline + LINE_W'(1);
        end

        href    = cfg_embedded ? emb_h : pin_h;
        vref    = cfg_embedded ? emb_v : pin_v;
        fid_act = cfg_embedded ? 1'b0  : rd_q.fid_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

endmodule

// File: rtl/vtg_start_delay.sv
module vtg_start_delay
    import vtg_pkg::*;
#(
    parameter int PIX_W  = 13,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              href,
    input  logic              vref,
    input  logic              fid_act,
    input  logic [PIX_W-1:0]  h_delay,
    input  logic [LINE_W-1:0] v_delay,
    output logic              start,
    output logic              start_field,
    output logic              busy
);

    typedef struct packed {
        sd_state_t         st;
        logic [PIX_W-1:0]  pcnt;
        logic [LINE_W-1:0] lcnt;
        logic              fid;
    } sd_regs_t;

    sd_regs_t sd_d, sd_q;

    always_comb begin
        sd_d  = sd_q;
        start = 1'b0;
        unique case (sd_q.st)
            SD_IDLE: begin
                if (vref) begin
                    sd_d.fid = fid_act;
                    if (v_delay == '0) begin
                        sd_d.st   = SD_PIX;
                        sd_d.pcnt = h_delay;
                    end else begin
                        sd_d.st   = SD_LINES;
                        sd_d.lcnt = v_delay;
                    end
                end
            end
            SD_LINES: begin
                // frame references are dropped here; only line references count
                if (href) begin
                    if (sd_q.lcnt <= LINE_W'(1)) begin
                        sd_d.st   = SD_PIX;
                        sd_d.pcnt = h_delay;
                    end else begin
                        sd_d.lcnt = sd_q.lcnt - LINE_W'(1);
                    end
                end
            end
            SD_PIX: begin
                // counts pixel clocks, so it runs across line ends freely
                if (sd_q.pcnt == '0) begin
                    start   = 1'b1;
                    sd_d.st = SD_IDLE;
                end else begin
                    sd_d.pcnt = sd_q.pcnt - PIX_W'(1);
                end
            end
            default: sd_d.st = SD_IDLE;
        endcase
        start_field = sd_q.fid;
        busy        = (sd_q.st != SD_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q <= '{st: SD_IDLE, pcnt: '0, lcnt: '0, fid: 1'b0};
        end else begin
            sd_q <= sd_d;
        end
    end

endmodule

// File: rtl/vtg_raster.sv
module vtg_raster #(
    parameter int PIX_W  = 13,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_field,
    input  logic [PIX_W-1:0]  pix_total,
    input  logic [LINE_W-1:0] line_total,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] line,
    output logic              field,
    output logic              run
);

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [LINE_W-1:0] line;
        logic              field;
        logic              run;
    } rs_regs_t;

    rs_regs_t rs_d, rs_q;

    logic [PIX_W-1:0]  pix_last;
    logic [LINE_W-1:0] line_last;

    always_comb begin
        pix_last  = pix_total  - PIX_W'(1);
        line_last = line_total - LINE_W'(1);
        rs_d      = rs_q;
        if (start) begin
            rs_d.pix   = '0;
            rs_d.line  = '0;
            rs_d.field = start_field;
            rs_d.run   = 1'b1;
        end else if (rs_q.run) begin
            if (rs_q.pix >= pix_last) begin
                rs_d.pix = '0;
                if (rs_q.line >= line_last) begin
                    rs_d.line  = '0;
                    rs_d.field = ~rs_q.field;
                end else begin
                    rs_d.line = rs_q.line + LINE_W'(1);
                end
            end else begin
                rs_d.pix = rs_q.pix + PIX_W'(1);
            end
        end
        pix   = rs_q.pix;
        line  = rs_q.line;
        field = rs_q.field;
        run   = rs_q.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

endmodule

// File: rtl/vtg_sync_out.sv
module vtg_sync_out #(
    parameter int PIX_W  = 13,
    parameter int LINE_W = 11
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    input  logic              field,
    input  logic              run,
    input  logic [PIX_W-1:0]  hs_width,
    input  logic [LINE_W-1:0] vs1_start,
    input  logic [LINE_W-1:0] vs1_width,
    input  logic [LINE_W-1:0] vs2_start,
    input  logic [LINE_W-1:0] vs2_width,
    input  logic              pol_hs_out,
    input  logic              pol_vs_out,
    output logic              hs_out,
    output logic              vs_out,
    output logic              field_out
);

    localparam int EW = LINE_W + 1;

    logic [EW-1:0] off1, off2;
    logic          win1, win2, hs_act, vs_act;

    always_comb begin
        off1   = {1'b0, line} - {1'b0, vs1_start};
        off2   = {1'b0, line} - {1'b0, vs2_start};
        win1   = (line >= vs1_start) && (off1 < {1'b0, vs1_width});
        win2   = (line >= vs2_start) && (off2 < {1'b0, vs2_width});
        hs_act = run && (pix < hs_width);
        vs_act = run && (field ? win2 : win1);
        // the two output polarity bits use opposite encodings
        hs_out    = pol_hs_out ? hs_act : ~hs_act;
        vs_out    = pol_vs_out ? ~vs_act : vs_act;
        field_out = run & field;
    end

endmodule

// File: rtl/vtg_sync_lock.sv
module vtg_sync_lock #(
    parameter int PIX_W  = 13,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_embedded,
    input  logic              pol_hs_in,
    input  logic              pol_vs_in,
    input  logic              pol_fid_in,
    input  logic              pol_hs_out,
    input  logic              pol_vs_out,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic              fid_in,
    input  logic              eav_strobe,
    input  logic [PIX_W-1:0]  h_delay,
    input  logic [LINE_W-1:0] v_delay,
    input  logic [PIX_W-1:0]  pix_total,
    input  logic [LINE_W-1:0] line_total,
    input  logic [PIX_W-1:0]  hs_width,
    input  logic [LINE_W-1:0] vs1_start,
    input  logic [LINE_W-1:0] vs1_width,
    input  logic [LINE_W-1:0] vs2_start,
    input  logic [LINE_W-1:0] vs2_width,
    output logic              hs_out,
    output logic              vs_out,
    output logic              field_out
);

    logic              href, vref, fid_act;
    logic              start, start_field, busy;
    logic [PIX_W-1:0]  pix;
    logic [LINE_W-1:0] line;
    logic              field, run;

    vtg_ref_detect #(.LINE_W(LINE_W)) i_ref (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_embedded (cfg_embedded),
        .pol_hs_in    (pol_hs_in),
        .pol_vs_in    (pol_vs_in),
        .pol_fid_in   (pol_fid_in),
        .hs_in        (hs_in),
        .vs_in        (vs_in),
        .fid_in       (fid_in),
        .eav_strobe   (eav_strobe),
        .line_total   (line_total),
        .href         (href),
        .vref         (vref),
        .fid_act      (fid_act)
    );

    vtg_start_delay #(.PIX_W(PIX_W), .LINE_W(LINE_W)) i_delay (
        .clk         (clk),
        .rst_n       (rst_n),
        .href        (href),
        .vref        (vref),
        .fid_act     (fid_act),
        .h_delay     (h_delay),
        .v_delay     (v_delay),
        .start       (start),
        .start_field (start_field),
        .busy        (busy)
    );

    vtg_raster #(.PIX_W(PIX_W), .LINE_W(LINE_W)) i_raster (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_field (start_field),
        .pix_total   (pix_total),
        .line_total  (line_total),
        .pix         (pix),
        .line        (line),
        .field       (field),
        .run         (run)
    );

    vtg_sync_out #(.PIX_W(PIX_W), .LINE_W(LINE_W)) i_out (
        .pix        (pix),
        .line       (line),
        .field      (field),
        .run        (run),
        .hs_width   (hs_width),
        .vs1_start  (vs1_start),
        .vs1_width  (vs1_width),
        .vs2_start  (vs2_start),
        .vs2_width  (vs2_width),
        .pol_hs_out (pol_hs_out),
        .pol_vs_out (pol_vs_out),
        .hs_out     (hs_out),
        .vs_out     (vs_out),
        .field_out  (field_out)
    );

endmodule

// File: rtl/vtg_sync_lock_chk.sv
module vtg_sync_lock_chk #(
    parameter int PIX_W  = 13,
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              run,
    input logic              field,
    input logic [PIX_W-1:0]  pix,
    input logic [LINE_W-1:0] line,
    input logic [PIX_W-1:0]  pix_total,
    input logic [LINE_W-1:0] vs2_width,
    input logic              pol_hs_out,
    input logic              pol_vs_out,
    input logic              hs_out,
    input logic              vs_out
);

    assert_restart_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (run && pix == '0 && line == '0));

    assert_start_from_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> busy);

    assert_pix_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pix_total != '0) |-> (pix < pix_total));

    assert_line_wrap_pix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(start) && pix_total != '0 && $stable(pix_total)
         && $past(pix) == pix_total - PIX_W'(1)) |-> (pix == '0));

    assert_quiet_before_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (hs_out == !pol_hs_out && vs_out == pol_vs_out));

    assert_no_field2_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && field && vs2_width == '0) |-> (vs_out == pol_vs_out));

endmodule

bind vtg_sync_lock vtg_sync_lock_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .run        (run),
    .field      (field),
    .pix        (pix),
    .line       (line),
    .pix_total  (pix_total),
    .vs2_width  (vs2_width),
    .pol_hs_out (pol_hs_out),
    .pol_vs_out (pol_vs_out),
    .hs_out     (hs_out),
    .vs_out     (vs_out)
);

// File: tb/test_vtg_sync_lock.sv
module test_vtg_sync_lock;

    localparam int PIX_W  = 13;
    localparam int LINE_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_embedded, pol_hs_in, pol_vs_in, pol_fid_in, pol_hs_out, pol_vs_out;
    logic hs_in, vs_in, fid_in, eav_strobe;
    logic [PIX_W-1:0]  h_delay, pix_total, hs_width;
    logic [LINE_W-1:0] v_delay, line_total, vs1_start, vs1_width, vs2_start, vs2_width;
    logic hs_out, vs_out, field_out;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vtg_sync_lock #(.PIX_W(PIX_W), .LINE_W(LINE_W)) i_vtg_sync_lock (
        .clk(clk), .rst_n(rst_n), .cfg_embedded(cfg_embedded),
        .pol_hs_in(pol_hs_in), .pol_vs_in(pol_vs_in), .pol_fid_in(pol_fid_in),
        .pol_hs_out(pol_hs_out), .pol_vs_out(pol_vs_out),
        .hs_in(hs_in), .vs_in(vs_in), .fid_in(fid_in), .eav_strobe(eav_strobe),
        .h_delay(h_delay), .v_delay(v_delay), .pix_total(pix_total),
        .line_total(line_total), .hs_width(hs_width),
        .vs1_start(vs1_start), .vs1_width(vs1_width),
        .vs2_start(vs2_start), .vs2_width(vs2_width),
        .hs_out(hs_out), .vs_out(vs_out), .field_out(field_out)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cyc, act, exp);
        end
    endtask

    task automatic goto(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // hold the chosen pins at their active level for edges k and k+1
    task automatic pin_ref(input int k, input bit do_hs, input bit do_vs);
        goto(k - 1);
        if (do_hs) hs_in = pol_hs_in;
        if (do_vs) vs_in = pol_vs_in;
        goto(k + 1);
        hs_in = ~pol_hs_in;
        vs_in = ~pol_vs_in;
    endtask

    task automatic eav_pulse(input int k);
        goto(k - 1);
        eav_strobe = 1'b1;
        goto(k);
        eav_strobe = 1'b0;
    endtask

    task automatic do_reset(output int k0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        k0 = cyc;
    endtask

    task automatic defaults;
        cfg_embedded = 1'b0;
        pol_hs_in = 1'b1; pol_vs_in = 1'b1; pol_fid_in = 1'b1;
        pol_hs_out = 1'b1; pol_vs_out = 1'b1;
        hs_in = 1'b0; vs_in = 1'b0; fid_in = 1'b0; eav_strobe = 1'b0;
        h_delay = 13'd61; v_delay = 11'd0;
        pix_total = 13'd20; line_total = 11'd4; hs_width = 13'd2;
        vs1_start = 11'd0; vs1_width = 11'd1;
        vs2_start = 11'd2047; vs2_width = 11'd0;
    endtask

    task automatic t_reset_state;
        int k0;
        defaults();
        do_reset(k0);
        chk("R8", "hs_out idle after reset", hs_out, 1'b0);
        chk("R8", "vs_out idle after reset", vs_out, 1'b1);
        chk("R8", "field_out after reset", field_out, 1'b0);
    endtask

    task automatic t_hdelay_pins;
        int k0, k;
        defaults();
        h_delay = 13'd5;
        do_reset(k0);
        k = k0 + 3;
        pin_ref(k, 1'b1, 1'b1);
        goto(k + 6); chk("R3", "hs before restart", hs_out, 1'b0);
        goto(k + 7); chk("R3", "hs at restart", hs_out, 1'b1);
    endtask

    task automatic t_active_low_in;
        int k0, k;
        defaults();
        pol_hs_in = 1'b0; pol_vs_in = 1'b0;
        hs_in = 1'b1; vs_in = 1'b1;
        h_delay = 13'd2; hs_width = 13'd3;
        do_reset(k0);
        k = k0 + 3;
        pin_ref(k, 1'b1, 1'b1);
        goto(k + 3); chk("R2", "active-low ref, hs before restart", hs_out, 1'b0);
        goto(k + 4); chk("R2", "active-low ref, hs at restart", hs_out, 1'b1);
        goto(k + 6); chk("R8", "hs last active pixel", hs_out, 1'b1);
        goto(k + 7); chk("R8", "hs after width", hs_out, 1'b0);
    endtask

    task automatic t_long_hdelay;
        int k0, k;
        defaults();
        h_delay = 13'd27;
        do_reset(k0);
        k = k0 + 3;
        pin_ref(k, 1'b1, 1'b1);
        pin_ref(k + 10, 1'b1, 1'b1);
        goto(k + 28); chk("R6", "extra refs ignored, hs before restart", hs_out, 1'b0);
        goto(k + 29); chk("R5", "h_delay beyond line, hs at restart", hs_out, 1'b1);
    endtask

    task automatic t_vdelay;
        int k0, k;
        defaults();
        h_delay = 13'd1; v_delay = 11'd3; line_total = 11'd2;
        do_reset(k0);
        k = k0 + 3;
        pin_ref(k, 1'b1, 1'b1);
        pin_ref(k + 20, 1'b1, 1'b1);
        pin_ref(k + 40, 1'b1, 1'b1);
        goto(k + 43); chk("R4", "no restart after two lines", hs_out, 1'b0);
        pin_ref(k + 60, 1'b1, 1'b0);
        goto(k + 62); chk("R5", "v_delay beyond frame, before restart", hs_out, 1'b0);
        goto(k + 63); chk("R4", "restart after third line ref", hs_out, 1'b1);
    endtask

    task automatic t_embedded;
        int k0, k;
        defaults();
        cfg_embedded = 1'b1;
        h_delay = 13'd0; v_delay = 11'd1;
        do_reset(k0);
        pin_ref(k0 + 2, 1'b1, 1'b1);
        goto(k0 + 10); chk("R1", "pins ignored in embedded mode", hs_out, 1'b0);
        k = k0 + 12;
        eav_pulse(k);
        goto(k + 3); chk("R1", "first strobe is frame ref only", hs_out, 1'b0);
        eav_pulse(k + 20);
        goto(k + 21); chk("R1", "before restart from strobe", hs_out, 1'b0);
        goto(k + 22); chk("R1", "restart from strobe", hs_out, 1'b1);
        chk("R10", "embedded field starts at 0", field_out, 1'b0);
    endtask

    task automatic t_raster_wrap;
        int k0, k;
        defaults();
        h_delay = 13'd0; pix_total = 13'd10; line_total = 11'd3;
        do_reset(k0);
        k = k0 + 3;
        pin_ref(k, 1'b1, 1'b1);
        goto(k + 2);  chk("R7", "pixel 0", hs_out, 1'b1);
        goto(k + 3);  chk("R7", "pixel 1", hs_out, 1'b1);
        goto(k + 4);  chk("R7", "pixel 2", hs_out, 1'b0);
        goto(k + 11); chk("R7", "last pixel", hs_out, 1'b0);
        goto(k + 12); chk("R7", "next line pixel 0", hs_out, 1'b1);
        goto(k + 31); chk("R7", "field before frame wrap", field_out, 1'b0);
        goto(k + 32); chk("R7", "field after frame wrap", field_out, 1'b1);
    endtask

    task automatic t_vs_fields;
        int k0, k;
        defaults();
        h_delay = 13'd0; pix_total = 13'd10; line_total = 11'd4;
        vs1_start = 11'd0; vs1_width = 11'd2;
        vs2_start = 11'd1; vs2_width = 11'd1;
        do_reset(k0);
        k = k0 + 3;
        fid_in = 1'b1;
        pin_ref(k, 1'b1, 1'b1);
        fid_in = 1'b0;
        goto(k + 3);  chk("R10", "field from fid pin", field_out, 1'b1);
        goto(k + 5);  chk("R9", "field2 line0 inactive", vs_out, 1'b1);
        goto(k + 15); chk("R9", "field2 line1 active low", vs_out, 1'b0);
        goto(k + 25); chk("R9", "field2 line2 inactive", vs_out, 1'b1);
        goto(k + 41); chk("R7", "field before wrap", field_out, 1'b1);
        goto(k + 42); chk("R7", "field after wrap", field_out, 1'b0);
        goto(k + 45); chk("R9", "field1 line0 active", vs_out, 1'b0);
        goto(k + 55); chk("R9", "field1 line1 active", vs_out, 1'b0);
        goto(k + 56); pol_vs_out = 1'b0;
        goto(k + 57); chk("R9", "active-high vs in window", vs_out, 1'b1);
        goto(k + 66); chk("R9", "active-high vs outside window", vs_out, 1'b0);
    endtask

    task automatic t_progressive;
        int k0, k;
        defaults();
        h_delay = 13'd0; pix_total = 13'd10; line_total = 11'd4;
        pol_fid_in = 1'b0; pol_hs_out = 1'b0;
        vs1_start = 11'd0; vs1_width = 11'd1;
        vs2_start = 11'd2047; vs2_width = 11'd0;
        do_reset(k0);
        k = k0 + 3;
        fid_in = 1'b0;
        pin_ref(k, 1'b1, 1'b1);
        fid_in = 1'b1;
        goto(k + 2);  chk("R8", "active-low hs at pixel 0", hs_out, 1'b0);
        goto(k + 3);  chk("R2", "active-low fid selects field 2", field_out, 1'b1);
        goto(k + 5);  chk("R11", "no field2 vs line0", vs_out, 1'b1);
        chk("R8", "active-low hs idle", hs_out, 1'b1);
        goto(k + 15); chk("R11", "no field2 vs line1", vs_out, 1'b1);
        goto(k + 25); chk("R11", "no field2 vs line2", vs_out, 1'b1);
        goto(k + 35); chk("R11", "no field2 vs line3", vs_out, 1'b1);
        goto(k + 45); chk("R9", "field1 vs line0", vs_out, 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        defaults();
        t_reset_state();
        t_hdelay_pins();
        t_active_low_in();
        t_long_hdelay();
        t_vdelay();
        t_embedded();
        t_raster_wrap();
        t_vs_fields();
        t_progressive();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule